// File: doc/BRIEF.md
# Machine Trap Vector Register and Target Generator

This block stores the machine trap-vector word: a base address together with a two-bit mode selector. Software reads and writes the word through a single-cycle register port. Each write is made legal before it is stored, so the stored word is always one the block can use. When the core takes a trap, it presents an interrupt flag and a cause number. The block then returns, combinationally, the address at which execution resumes.

There are two modes. In Direct mode every trap lands on the base address. In Vectored mode, synchronous exceptions still land on the base address, while an interrupt lands on the base plus four times its cause number.

The base alignment required in Vectored mode is a parameter. When that alignment covers the whole cause table, the low base bits are always zero, so the cause offset is inserted into them with an OR and no carry chain. When the alignment is the plain 4-byte minimum, an adder forms the target. Both variants give the same address for any base that meets the coarser alignment.

Top module: `tvec_unit`

## Requirements
- R1: After reset, `csr_rdata` equals `RESET_BASE` with bits [1:0] cleared, and the mode is Direct (bits [1:0] = 0).
- R2: A write whose bits [1:0] are 0 (Direct) or 1 (Vectored) stores that mode. From the next cycle, `csr_rdata` returns the legalized word.
- R3: A write whose bits [1:0] are 2 or 3 keeps the previously stored mode, while the base part of the write is still taken.
- R4: In Direct mode, `trap_pc` equals the stored base with bits [1:0] zero, for every value of `trap_intr` and `trap_cause`.
- R5: In Vectored mode, a trap with `trap_intr` low gives `trap_pc` equal to the stored base.
- R6: In Vectored mode, an interrupt gives `trap_pc` = base + 4 × `trap_cause`. For example, cause 7 gives base + 0x1c.
- R7: In Vectored mode, interrupt cause 0 gives the same target as a synchronous exception.
- R8: Any write that leaves the mode Vectored clears the base bits [log2(VEC_ALIGN)-1:2]. A write that leaves the mode Direct keeps all of bits [XLEN-1:2].
- R9: The insertion variant (VEC_ALIGN ≥ 4 × 2^ceil(log2 NCAUSE)) and the adder variant (VEC_ALIGN = 4) produce identical `trap_pc` when given identical writes whose base is aligned to the coarse alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Write strobe for the vector word |
| csr_wdata | input | XLEN | Write data: base in [XLEN-1:2], mode in [1:0] |
| csr_rdata | output | XLEN | Legalized stored vector word |
| trap_intr | input | 1 | High when the trap is an interrupt |
| trap_cause | input | ceil(log2 NCAUSE) | Cause number of the trap |
| trap_pc | output | XLEN | Trap target address |

## Verification
The bench writes eight base patterns, half of them aligned to the cause table and half carrying set bits in the low base field. It cycles each pattern through the mode codes 0, 2, 1 and 3, so that a reserved code is seen both while Direct and while Vectored is held. After every write it sweeps both values of the interrupt flag and all sixteen cause numbers. This separates Direct from Vectored, exceptions from interrupts, and cause 0 from the other causes. Two instances, one using insertion and one using an adder, receive the same writes. The unaligned bases show that only the coarse variant clears the low field, and the aligned bases show that the two variants agree.

// File: rtl/tvec_pkg.sv
package tvec_pkg;

    typedef enum logic [1:0] {
        TV_DIRECT   = 2'd0,
        TV_VECTORED = 2'd1,
        TV_RSVD2    = 2'd2,
        TV_RSVD3    = 2'd3
    } tv_mode_e;

    // Only codes with the upper bit clear are usable modes.
    function automatic logic tv_mode_ok(input logic [1:0] code);
        return (code[1] == 1'b0);
    endfunction

endpackage

// File: rtl/tvec_legal.sv
module tvec_legal #(
    parameter int XLEN    = 32,
    parameter int VEC_LSB = 6
) (
    input  logic [XLEN-1:0] cur_vec,
    input  logic [XLEN-1:0] wr_vec,
    output logic [XLEN-1:0] legal_vec
);
    import tvec_pkg::*;

    localparam logic [XLEN-1:0] VEC_KEEP = ~((XLEN'(1) << VEC_LSB) - XLEN'(1));

    logic [1:0]      mode_sel;
    logic [XLEN-1:0] base_sel;

    always_comb begin
        mode_sel = tv_mode_ok(wr_vec[1:0]) ? wr_vec[1:0] : cur_vec[1:0];
        base_sel = {wr_vec[XLEN-1:2], 2'b00};
        if (mode_sel == TV_VECTORED) begin
            base_sel = base_sel & VEC_KEEP;
        end
        legal_vec = base_sel | {{(XLEN-2){1'b0}}, mode_sel};
    end

endmodule

// File: rtl/tvec_target.sv
module tvec_target #(
    parameter int XLEN       = 32,
    parameter int CW         = 4,
    parameter bit USE_INSERT = 1'b1
) (
    input  logic [XLEN-1:0] vec,
    input  logic            intr,
    input  logic [CW-1:0]   cause,
    output logic [XLEN-1:0] pc
);
    import tvec_pkg::*;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offs;
    logic            take_vec;

    always_comb begin
        base     = {vec[XLEN-1:2], 2'b00};
        offs     = {{(XLEN-CW-2){1'b0}}, cause, 2'b00};
        take_vec = (vec[1:0] == TV_VECTORED) && intr;
    end

    generate
        if (USE_INSERT) begin : g_insert
            // Low base bits are guaranteed zero, so OR acts as the add.
            always_comb pc = take_vec ? (base | offs) : base;
        end else begin : g_adder
            always_comb pc = take_vec ? (base + offs) : base;
        end
    endgenerate

endmodule

// File: rtl/tvec_unit.sv
module tvec_unit #(
    parameter int              XLEN       = 32,
    parameter int              NCAUSE     = 16,
    parameter int              VEC_ALIGN  = 4 * NCAUSE,
    parameter logic [XLEN-1:0] RESET_BASE = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       csr_we,
    input  logic [XLEN-1:0]            csr_wdata,
    output logic [XLEN-1:0]            csr_rdata,
    input  logic                       trap_intr,
    input  logic [$clog2(NCAUSE)-1:0]  trap_cause,
    output logic [XLEN-1:0]            trap_pc
);
    import tvec_pkg::*;

    localparam int CW         = $clog2(NCAUSE);
    localparam int CAUSE_SPAN = 1 << CW;
    localparam int VEC_LSB    = $clog2(VEC_ALIGN);
    localparam bit USE_INSERT = (VEC_ALIGN >= 4 * CAUSE_SPAN);

    typedef struct packed {
        logic [XLEN-1:2] base;
        tv_mode_e        mode;
    } tvec_st_t;

    tvec_st_t        st_d, st_q;
    logic [XLEN-1:0] legal_vec;

    tvec_legal #(.XLEN(XLEN), .VEC_LSB(VEC_LSB)) legal_i (
        .cur_vec   (st_q),
        .wr_vec    (csr_wdata),
        .legal_vec (legal_vec)
    );

    always_comb begin
        st_d = st_q;
        if (csr_we) begin
            st_d = tvec_st_t'(legal_vec);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.base <= RESET_BASE[XLEN-1:2];
            st_q.mode <= TV_DIRECT;
        end else begin
            st_q <= st_d;
        end
    end

    assign csr_rdata = st_q;

    tvec_target #(.XLEN(XLEN), .CW(CW), .USE_INSERT(USE_INSERT)) target_i (
        .vec   (st_q),
        .intr  (trap_intr),
        .cause (trap_cause),
        .pc    (trap_pc)
    );

endmodule

// File: rtl/tvec_unit_chk.sv
module tvec_unit_chk #(
    parameter int XLEN      = 32,
    parameter int NCAUSE    = 16,
    parameter int VEC_ALIGN = 4 * NCAUSE
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      csr_we,
    input logic [XLEN-1:0]           csr_wdata,
    input logic [XLEN-1:0]           csr_rdata,
    input logic                      trap_intr,
    input logic [$clog2(NCAUSE)-1:0] trap_cause,
    input logic [XLEN-1:0]           trap_pc
);
    localparam int CW      = $clog2(NCAUSE);
    localparam int VEC_LSB = $clog2(VEC_ALIGN);
    localparam logic [XLEN-1:0] LOW_FIELD = ((XLEN'(1) << VEC_LSB) - XLEN'(1)) & ~XLEN'(3);

    logic [XLEN-1:0] base_w;
    logic [XLEN-1:0] offs_w;
    assign base_w = {csr_rdata[XLEN-1:2], 2'b00};
    assign offs_w = {{(XLEN-CW-2){1'b0}}, trap_cause, 2'b00};

    // R2
    mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && !csr_wdata[1]) |=> (csr_rdata[1:0] == $past(csr_wdata[1:0])));

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_wdata[1]) |=> (csr_rdata[1:0] == $past(csr_rdata[1:0])));

    // R4
    direct_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[1:0] == 2'd0) |-> (trap_pc == base_w));

    // R5
    vec_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[1:0] == 2'd1 && !trap_intr) |-> (trap_pc == base_w));

    // R6
    vec_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[1:0] == 2'd1 && trap_intr) |-> (trap_pc == base_w + offs_w));

    // R8
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[1:0] == 2'd1) |-> ((csr_rdata & LOW_FIELD) == '0));

endmodule

bind tvec_unit tvec_unit_chk #(
    .XLEN(XLEN), .NCAUSE(NCAUSE), .VEC_ALIGN(VEC_ALIGN)
) chk_i (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .trap_intr(trap_intr), .trap_cause(trap_cause),
    .trap_pc(trap_pc)
);

// File: tb/tvec_unit_tb_top.sv
`timescale 1ns/1ps
module tvec_unit_tb_top;
    localparam int XLEN   = 32;
    localparam int NCAUSE = 16;
    localparam int CW     = 4;
    localparam int LSB_C  = 6;   // log2(64): coarse variant
    localparam int LSB_A  = 2;   // log2(4): adder variant

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_we = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic            trap_intr = 1'b0;
    logic [CW-1:0]   trap_cause = '0;
    logic [XLEN-1:0] rdata_c, rdata_a, pc_c, pc_a;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tvec_unit #(.XLEN(XLEN), .NCAUSE(NCAUSE), .VEC_ALIGN(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(rdata_c), .trap_intr(trap_intr), .trap_cause(trap_cause),
        .trap_pc(pc_c)
    );

    tvec_unit #(.XLEN(XLEN), .NCAUSE(NCAUSE), .VEC_ALIGN(4)) dut_add_i (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(rdata_a), .trap_intr(trap_intr), .trap_cause(trap_cause),
        .trap_pc(pc_a)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] legal(input logic [31:0] cur, input logic [31:0] wd, input int lsb);
        logic [1:0]  m;
        logic [31:0] b;
        m = wd[1] ? cur[1:0] : wd[1:0];
        b = {wd[31:2], 2'b00};
        if (m == 2'd1) b = b & ~((32'd1 << lsb) - 32'd1);
        return b | {30'd0, m};
    endfunction

    function automatic logic [31:0] tgt(input logic [31:0] v, input logic intr, input int cause);
        logic [31:0] b;
        b = {v[31:2], 2'b00};
        if (v[1:0] == 2'd1 && intr) return b + 32'(cause * 4);
        return b;
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] mc, ma;
        int order [4] = '{0, 2, 1, 3};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 reset word coarse", rdata_c, 32'd0);
        chk("R1 reset word adder", rdata_a, 32'd0);
        mc = 32'd0;
        ma = 32'd0;
        for (int k = 0; k < 8; k++) begin
            logic [31:0] base;
            base = 32'h8000_0000 ^ (32'(k) * 32'h1357_9bdc);
            if (k % 2 == 0) base = base & ~32'h3f;
            for (int j = 0; j < 4; j++) begin
                logic [31:0] wd;
                wd = {base[31:2], 2'(order[j])};
                csr_we = 1'b1;
                csr_wdata = wd;
                @(posedge clk);
                @(negedge clk);
                csr_we = 1'b0;
                mc = legal(mc, wd, LSB_C);
                ma = legal(ma, wd, LSB_A);
                chk(order[j] >= 2 ? "R3 reserved mode write coarse" : "R2 mode write coarse", rdata_c, mc);
                chk(order[j] >= 2 ? "R3 reserved mode write adder" : "R2 mode write adder", rdata_a, ma);
                if (rdata_c[1:0] == 2'd1)
                    chk("R8 vectored low base field cleared", rdata_c & 32'h3c, 32'd0);
                else
                    chk("R8 direct base bits kept", rdata_c[31:2], wd[31:2]);
                for (int it = 0; it < 2; it++) begin
                    for (int c = 0; c < NCAUSE; c++) begin
                        string tag;
                        trap_intr = it[0];
                        trap_cause = CW'(c);
                        #2;
                        if (mc[1:0] == 2'd0) tag = "R4 direct target";
                        else if (it == 0) tag = "R5 vectored exception target";
                        else if (c == 0) tag = "R7 vectored cause 0 target";
                        else tag = "R6 vectored interrupt target";
                        chk(tag, pc_c, tgt(mc, it[0], c));
                        chk(tag, pc_a, tgt(ma, it[0], c));
                        if (mc == ma) chk("R9 insertion vs adder target", pc_c, pc_a);
                        if (mc[1:0] == 2'd1 && it == 1 && c == 0)
                            chk("R7 cause 0 equals exception", pc_c, {mc[31:2], 2'b00});
                        if (mc[1:0] == 2'd1 && it == 1 && c == 7)
                            chk("R6 cause 7 offset 0x1c", pc_c, {mc[31:2], 2'b00} + 32'h1c);
                    end
                end
                trap_intr = 1'b0;
                trap_cause = '0;
                @(negedge clk);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule